// File: doc/BRIEF.md
# Ethernet Transmit Framer with Automatic Padding

This block turns the bytes waiting in a transmit FIFO into a complete Ethernet/802.3 frame on a serial bit output, one bit per clock. It stays idle until two things are true: the FIFO holds at least a programmed number of bytes, and the channel-permit input allows transmission. It then sends seven preamble bytes and the start frame delimiter, followed by the frame bytes it reads from the FIFO until it sees the end-of-packet flag. If the frame is too short, it adds zero bytes itself. It finishes with a CRC-32 frame check sequence that it computes on the fly.

Two configuration bits are captured when each frame starts. The padding bit decides whether short frames are filled with zero bytes until the frame, FCS included, reaches 64 bytes. The FCS bit decides whether the check sequence is appended at all. Transmit enable stays high over the whole frame and then drops for at least one cycle before the next start. Collision handling, retries and line encoding belong to other blocks.

Top module: `eth_tx_framer`

## Requirements
- R1: Transmit enable rises only in the clock after one in which `chan_ok` was high and `fifo_level` was nonzero and not below `start_thresh`.
- R2: Each frame opens with 56 bits that alternate 1,0,1,0..., starting with a 1. This is seven bytes of 0x55, each sent LSB first.
- R3: The 56 preamble bits are followed by the delimiter byte 0xD5 sent LSB first, which gives the bit order 1,0,1,0,1,0,1,1.
- R4: After the delimiter, FIFO bytes are sent LSB first in FIFO order. Each byte takes one `fifo_rd` pulse, and reading stops with the byte whose `fifo_eop` is 1.
- R5: When padding is enabled and fewer than 60 data bytes were read, 0x00 bytes follow the data until data plus pad makes 60 bytes. Frames of 60 or more data bytes get no pad.
- R6: When padding is disabled, no pad bytes are inserted, whatever the frame length.
- R7: When FCS is enabled, 32 FCS bits follow the data and pad. The FCS is the one's complement of a CRC-32 with polynomial 0x04C11DB7 and all-ones preset, taken over the data and pad bits in the order they are sent, and it is output from its most significant bit down.
- R8: When FCS is disabled, the frame ends after the last data or pad bit.
- R9: Transmit enable and `fifo_rd` are low during reset. Transmit enable stays high without a gap from the first preamble bit to the last bit of the frame, so each frame is a whole number of bytes and at least 72 bits long.
- R10: `pad_en` and `fcs_en` are sampled only in the cycle a frame starts. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one serial bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_data | input | 8 | Byte at the head of the transmit FIFO (show-ahead) |
| fifo_eop | input | 1 | Head byte is the last byte of the frame |
| fifo_level | input | LEVEL_W | Number of bytes currently held in the FIFO |
| fifo_rd | output | 1 | Pops the head byte at the next clock edge |
| start_thresh | input | LEVEL_W | Fill level needed before a frame may start |
| chan_ok | input | 1 | Channel access is permitted |
| pad_en | input | 1 | Pad short frames with zero bytes |
| fcs_en | input | 1 | Append the frame check sequence |
| tx_bit | output | 1 | Serial transmit data |
| tx_en | output | 1 | Transmit enable, high for the whole frame |

## Verification
The assertions assume that the FIFO never runs dry inside a frame. In other words, once a frame has started, every `fifo_rd` finds a valid head byte and the end-of-packet byte eventually comes. The bench's FIFO model keeps to this: it writes one byte per cycle, which is faster than the framer reads (one byte every eight cycles), and every frame it writes carries exactly one end flag. The start condition is checked only against `fifo_level`, `start_thresh` and `chan_ok`. The stimulus holds each of these back in turn, and only then releases the frame.

// File: rtl/eth_tx_pkg.sv
// Shared constants and state type for the Ethernet transmit framer.
// Assumes: bytes are serialised least significant bit first.
package eth_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_DATA,
        ST_PAD,
        ST_FCS
    } tx_state_t;

    localparam logic [7:0]  PRE_BYTE  = 8'h55;          // 1,0,1,0... on the wire
    localparam logic [7:0]  SFD_BYTE  = 8'hD5;          // 1,0,1,0,1,0,1,1 on the wire
    localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;
    localparam int          FCS_BITS  = 32;

endpackage

// File: rtl/eth_tx_crc32.sv
// Bit-serial CRC-32 generator for the framer.
// Feeds one data bit per cycle MSB-register style, then drains the
// complemented register MSB first as the FCS.
// Assumes: init, feed and drain are never requested in the same cycle.
module eth_tx_crc32
    import eth_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic feed,
    input  logic din,
    input  logic drain,
    output logic fcs_bit
);

    logic [31:0] crc_q;
    logic        fb;

    assign fb      = crc_q[31] ^ din;
    assign fcs_bit = ~crc_q[31];

    // Register update: preset, accumulate a bit, or shift out the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_PRESET;
        end else if (init) begin
            crc_q <= CRC_PRESET;
        end else if (feed) begin
            crc_q <= {crc_q[30:0], 1'b0} ^ ({32{fb}} & CRC_POLY);
        end else if (drain) begin
            crc_q <= {crc_q[30:0], 1'b1};
        end
    end

endmodule

// File: rtl/eth_tx_shifter.sv
// Byte parallel-to-serial shifter, LSB first.
// Assumes: load takes priority over shift; the byte is held until the
// controller has shown all of its bits.
module eth_tx_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              shift,
    output logic              ser_bit
);

    logic [BYTE_W-1:0] sh_q;

    assign ser_bit = sh_q[0];

    // Load a new byte or move the next bit into position 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= load_byte;
        end else if (shift) begin
            sh_q <= {1'b0, sh_q[BYTE_W-1:1]};
        end
    end

endmodule

// File: rtl/eth_tx_ctrl.sv
// Frame sequencer: start gating, preamble/delimiter/data/pad/FCS phases,
// FIFO reads and the per-frame option latch.
// Assumes: the FIFO is show-ahead and holds a valid byte whenever a read is
// issued inside a frame.
module eth_tx_ctrl
    import eth_tx_pkg::*;
#(
    parameter int LEVEL_W   = 8,
    parameter int MIN_FRAME = 64,
    parameter int PRE_LEN   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         fifo_data,
    input  logic               fifo_eop,
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic [LEVEL_W-1:0] start_thresh,
    input  logic               chan_ok,
    input  logic               pad_en,
    input  logic               fcs_en,
    output logic               fifo_rd,
    output logic               sh_load,
    output logic [7:0]         sh_byte,
    output logic               sh_shift,
    output logic               crc_init,
    output logic               crc_feed,
    output logic               crc_drain,
    output logic               sel_fcs,
    output logic               tx_en
);

    localparam int DATA_MIN = MIN_FRAME - FCS_BITS / 8;
    localparam int CNT_W    = $clog2(DATA_MIN + 1);
    localparam int PRE_W    = $clog2(PRE_LEN + 1);
    localparam int BIT_W    = $clog2(FCS_BITS);

    tx_state_t          state_q, state_d;
    logic [BIT_W-1:0]   bit_cnt_q;
    logic [CNT_W-1:0]   byte_cnt_q;
    logic [PRE_W-1:0]   pre_cnt_q;
    logic               last_q, pad_q, fcs_q;
    logic               start, byte_end, fcs_end, need_pad, cnt_byte;

    assign start    = (state_q == ST_IDLE) && chan_ok && (fifo_level != '0)
                      && (fifo_level >= start_thresh);
    assign byte_end = (bit_cnt_q == BIT_W'(7));
    assign fcs_end  = (bit_cnt_q == BIT_W'(FCS_BITS - 1));
    assign need_pad = pad_q && (byte_cnt_q < CNT_W'(DATA_MIN));

    assign tx_en     = (state_q != ST_IDLE);
    assign sel_fcs   = (state_q == ST_FCS);
    assign crc_feed  = (state_q == ST_DATA) || (state_q == ST_PAD);
    assign crc_drain = (state_q == ST_FCS);
    assign crc_init  = start;
    assign sh_shift  = tx_en && !sh_load;
    assign cnt_byte  = fifo_rd || (sh_load && state_d == ST_PAD);

    // Next phase, FIFO read and shifter load decision for each cycle.
    always_comb begin
        state_d = state_q;
        fifo_rd = 1'b0;
        sh_load = 1'b0;
        sh_byte = 8'h00;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_PRE;
                    sh_load = 1'b1;
                    sh_byte = PRE_BYTE;
                end
            end
            ST_PRE: begin
                if (byte_end) begin
                    sh_load = 1'b1;
                    if (pre_cnt_q == PRE_W'(PRE_LEN - 1)) begin
                        state_d = ST_SFD;
                        sh_byte = SFD_BYTE;
                    end else begin
                        sh_byte = PRE_BYTE;
                    end
                end
            end
            ST_SFD: begin
                if (byte_end) begin
                    state_d = ST_DATA;
                    fifo_rd = 1'b1;
                    sh_load = 1'b1;
                    sh_byte = fifo_data;
                end
            end
            ST_DATA: begin
                if (byte_end) begin
                    if (!last_q) begin
                        fifo_rd = 1'b1;
                        sh_load = 1'b1;
                        sh_byte = fifo_data;
                    end else if (need_pad) begin
                        state_d = ST_PAD;
                        sh_load = 1'b1;
                    end else if (fcs_q) begin
                        state_d = ST_FCS;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_PAD: begin
                if (byte_end) begin
                    if (need_pad) begin
                        sh_load = 1'b1;
                    end else if (fcs_q) begin
                        state_d = ST_FCS;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_FCS: begin
                if (fcs_end) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Bit position within the current byte or FCS word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
        end else if (sh_load || state_d != state_q) begin
            bit_cnt_q <= '0;
        end else if (tx_en) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    // Preamble byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE) begin
            pre_cnt_q <= '0;
        end else if (state_q == ST_PRE && byte_end) begin
            pre_cnt_q <= pre_cnt_q + 1'b1;
        end
    end

    // Data plus pad byte counter, saturating at the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE) begin
            byte_cnt_q <= '0;
        end else if (cnt_byte && byte_cnt_q < CNT_W'(DATA_MIN)) begin
            byte_cnt_q <= byte_cnt_q + 1'b1;
        end
    end

    // End flag of the byte now in the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE) last_q <= 1'b0;
        else if (fifo_rd)                  last_q <= fifo_eop;
    end

    // Per-frame option latch, captured at start only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_q <= 1'b0;
            fcs_q <= 1'b0;
        end else if (start) begin
            pad_q <= pad_en;
            fcs_q <= fcs_en;
        end
    end

endmodule

// File: rtl/eth_tx_framer.sv
// Top of the Ethernet transmit framer: sequencer, byte shifter and CRC.
// Assumes: show-ahead FIFO that does not underrun inside a frame.
module eth_tx_framer #(
    parameter int LEVEL_W   = 8,
    parameter int MIN_FRAME = 64,
    parameter int PRE_LEN   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         fifo_data,
    input  logic               fifo_eop,
    input  logic [LEVEL_W-1:0] fifo_level,
    output logic               fifo_rd,
    input  logic [LEVEL_W-1:0] start_thresh,
    input  logic               chan_ok,
    input  logic               pad_en,
    input  logic               fcs_en,
    output logic               tx_bit,
    output logic               tx_en
);

    logic       sh_load, sh_shift, sh_bit;
    logic [7:0] sh_byte;
    logic       crc_init, crc_feed, crc_drain, crc_bit, sel_fcs;

    eth_tx_ctrl #(
        .LEVEL_W  (LEVEL_W),
        .MIN_FRAME(MIN_FRAME),
        .PRE_LEN  (PRE_LEN)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_data   (fifo_data),
        .fifo_eop    (fifo_eop),
        .fifo_level  (fifo_level),
        .start_thresh(start_thresh),
        .chan_ok     (chan_ok),
        .pad_en      (pad_en),
        .fcs_en      (fcs_en),
        .fifo_rd     (fifo_rd),
        .sh_load     (sh_load),
        .sh_byte     (sh_byte),
        .sh_shift    (sh_shift),
        .crc_init    (crc_init),
        .crc_feed    (crc_feed),
        .crc_drain   (crc_drain),
        .sel_fcs     (sel_fcs),
        .tx_en       (tx_en)
    );

    eth_tx_shifter #(.BYTE_W(8)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_byte(sh_byte),
        .shift    (sh_shift),
        .ser_bit  (sh_bit)
    );

    eth_tx_crc32 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (crc_init),
        .feed   (crc_feed),
        .din    (sh_bit),
        .drain  (crc_drain),
        .fcs_bit(crc_bit)
    );

    assign tx_bit = sel_fcs ? crc_bit : sh_bit;

endmodule

// File: rtl/eth_tx_framer_chk.sv
// Protocol checker for eth_tx_framer, attached by bind.
// Assumes: the FIFO never underruns inside a frame.
module eth_tx_framer_chk #(
    parameter int LEVEL_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [LEVEL_W-1:0] fifo_level,
    input logic [LEVEL_W-1:0] start_thresh,
    input logic               chan_ok,
    input logic               fifo_rd,
    input logic               tx_en
);

    logic [15:0] run_len;

    // Length of the current transmit-enable burst.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) run_len <= '0;
        else if (run_len != 16'hFFFF) run_len <= run_len + 1'b1;
    end

    // R1
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(chan_ok && fifo_level != '0 && fifo_level >= start_thresh));

    // R4
    rd_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> tx_en);

    // R4
    rd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> !fifo_rd);

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!tx_en && !fifo_rd));

    // R9
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> (run_len >= 16'd72 && run_len[2:0] == 3'd0));

endmodule

bind eth_tx_framer eth_tx_framer_chk #(.LEVEL_W(LEVEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_level  (fifo_level),
    .start_thresh(start_thresh),
    .chan_ok     (chan_ok),
    .fifo_rd     (fifo_rd),
    .tx_en       (tx_en)
);

// File: tb/eth_tx_framer_tb.sv
module eth_tx_framer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LEVEL_W    = 8;
    localparam int WATCHDOG   = 150000;

    typedef struct {
        logic b;
        int   sect;   // 0 preamble, 1 sfd, 2 data, 3 pad, 4 fcs
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] fifo_data;
    logic fifo_eop;
    logic [LEVEL_W-1:0] fifo_level;
    logic fifo_rd;
    logic [LEVEL_W-1:0] start_thresh = 8'd1;
    logic chan_ok = 1'b0;
    logic pad_en = 1'b0;
    logic fcs_en = 1'b0;
    logic tx_bit, tx_en;

    logic [7:0] mem [0:255];
    logic       eop_mem [0:255];
    int wr_ptr = 0;
    int rd_ptr = 0;

    exp_t exp_q[$];
    logic [7:0] fr [0:127];
    int sect_err [0:4];
    int extra_bits = 0;
    int rd_count = 0;
    int done_cnt = 0;
    logic prev_en = 1'b0;
    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign fifo_level = LEVEL_W'(wr_ptr - rd_ptr);
    assign fifo_data  = mem[rd_ptr % 256];
    assign fifo_eop   = eop_mem[rd_ptr % 256];

    eth_tx_framer #(.LEVEL_W(LEVEL_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .fifo_data(fifo_data), .fifo_eop(fifo_eop), .fifo_level(fifo_level),
        .fifo_rd(fifo_rd), .start_thresh(start_thresh), .chan_ok(chan_ok),
        .pad_en(pad_en), .fcs_en(fcs_en), .tx_bit(tx_bit), .tx_en(tx_en)
    );

    // FIFO model pop
    always @(posedge clk) if (fifo_rd) rd_ptr <= rd_ptr + 1;

    initial begin
        for (int i = 0; i < 5; i++) sect_err[i] = 0;
    end

    // Monitor: pops expected bits while transmit enable is high
    always @(negedge clk) begin
        cyc <= cyc + 1;
        prev_en <= tx_en;
        if (rst_n && fifo_rd) rd_count <= rd_count + 1;
        if (rst_n && tx_en) begin
            if (exp_q.size() == 0) begin
                extra_bits <= extra_bits + 1;
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.b !== tx_bit) sect_err[e.sect] <= sect_err[e.sect] + 1;
            end
        end
        if (!tx_en && prev_en) done_cnt <= done_cnt + 1;
    end

    task automatic check(string req, int got, int expv, string what);
        n_tests++;
        if (got != expv) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
        end
    endtask

    task automatic push_bits(logic [7:0] b, int sect);
        for (int i = 0; i < 8; i++) begin
            exp_t e;
            e.b = b[i];
            e.sect = sect;
            exp_q.push_back(e);
        end
    endtask

    // Driver side of the scoreboard: builds frame bytes and expected bits
    task automatic prepare(int n, int kind, bit pad, bit fcs);
        logic [31:0] crc;
        logic [7:0]  b;
        int total;
        for (int i = 0; i < n; i++) begin
            case (kind)
                0: fr[i] = 8'(i + 1);
                1: fr[i] = 8'($urandom);
                default: fr[i] = 8'hFF;
            endcase
        end
        for (int i = 0; i < 7; i++) push_bits(8'h55, 0);
        push_bits(8'hD5, 1);
        crc = 32'hFFFF_FFFF;
        total = (pad && n < 60) ? 60 : n;
        for (int i = 0; i < total; i++) begin
            b = (i < n) ? fr[i] : 8'h00;
            push_bits(b, (i < n) ? 2 : 3);
            crc = crc ^ {24'h0, b};
            for (int k = 0; k < 8; k++)
                crc = crc[0] ? ((crc >> 1) ^ 32'hEDB8_8320) : (crc >> 1);
        end
        crc = ~crc;
        if (fcs) begin
            for (int i = 0; i < 32; i++) begin
                exp_t e;
                e.b = crc[i];
                e.sect = 4;
                exp_q.push_back(e);
            end
        end
    endtask

    task automatic push_byte(logic [7:0] b, logic eop);
        @(negedge clk);
        mem[wr_ptr % 256] = b;
        eop_mem[wr_ptr % 256] = eop;
        wr_ptr = wr_ptr + 1;
    endtask

    task automatic wait_done(int base);
        while (done_cnt == base) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_frame(string tag, int n, bit pad, bit fcs, int e0 [0:4], int x0, int r0);
        check("R2", sect_err[0] - e0[0], 0, {tag, " preamble bit errors"});
        check("R3", sect_err[1] - e0[1], 0, {tag, " delimiter bit errors"});
        check("R4", sect_err[2] - e0[2], 0, {tag, " data bit errors"});
        check("R4", rd_count - r0, n, {tag, " fifo reads"});
        if (pad && n < 60) check("R5", sect_err[3] - e0[3], 0, {tag, " pad bit errors"});
        if (fcs) check("R7", sect_err[4] - e0[4], 0, {tag, " fcs bit errors"});
        check(pad ? (fcs ? "R9" : "R8") : "R6", exp_q.size() + (extra_bits - x0), 0,
              {tag, " missing plus surplus bits"});
        exp_q.delete();
    endtask

    task automatic run_frame(string tag, int n, int kind, bit pad, bit fcs, bit flip);
        int e0 [0:4];
        int x0, r0, d0;
        for (int i = 0; i < 5; i++) e0[i] = sect_err[i];
        x0 = extra_bits; r0 = rd_count; d0 = done_cnt;
        prepare(n, kind, pad, fcs);
        pad_en = pad; fcs_en = fcs;
        start_thresh = 8'd1; chan_ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            push_byte(fr[i], i == n - 1);
            if (flip && i == 3) begin
                pad_en = ~pad;  // R10: late change must not matter
                fcs_en = ~fcs;
            end
        end
        wait_done(d0);
        finish_frame(tag, n, pad, fcs, e0, x0, r0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'h00;
            eop_mem[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check("R9", int'(tx_en), 0, "tx_en in reset");
        check("R9", int'(fifo_rd), 0, "fifo_rd in reset");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: threshold and channel gating
        begin
            int e0 [0:4];
            int x0, r0, d0;
            for (int i = 0; i < 5; i++) e0[i] = sect_err[i];
            x0 = extra_bits; r0 = rd_count; d0 = done_cnt;
            prepare(10, 0, 1'b1, 1'b1);
            pad_en = 1'b1; fcs_en = 1'b1;
            start_thresh = 8'd10; chan_ok = 1'b1;
            for (int i = 0; i < 9; i++) begin
                push_byte(fr[i], 1'b0);
                repeat (4) @(negedge clk);
            end
            repeat (20) @(negedge clk);
            check("R1", int'(tx_en), 0, "tx_en below threshold");
            chan_ok = 1'b0;
            push_byte(fr[9], 1'b1);
            repeat (30) @(negedge clk);
            check("R1", int'(tx_en), 0, "tx_en without channel permit");
            chan_ok = 1'b1;
            @(negedge clk);
            @(negedge clk);
            check("R1", int'(tx_en), 1, "tx_en after permit");
            wait_done(d0);
            finish_frame("gated10", 10, 1'b1, 1'b1, e0, x0, r0);
        end

        run_frame("short14", 14, 0, 1'b1, 1'b1, 1'b0);
        run_frame("long70", 70, 1, 1'b1, 1'b1, 1'b0);
        run_frame("exact60", 60, 1, 1'b1, 1'b1, 1'b0);
        run_frame("under59", 59, 2, 1'b1, 1'b1, 1'b0);
        run_frame("nopad20", 20, 1, 1'b0, 1'b1, 1'b0);   // R6
        run_frame("nofcs20", 20, 0, 1'b1, 1'b0, 1'b0);   // R8
        run_frame("bare1", 1, 2, 1'b0, 1'b0, 1'b0);      // R6 R8
        run_frame("flip_r10", 16, 1, 1'b1, 1'b1, 1'b1);  // R10
        run_frame("flip2_r10", 16, 0, 1'b0, 1'b0, 1'b1); // R10

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        while (cyc < WATCHDOG) @(negedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule